// File: doc/BRIEF.md
# Registered Difference-Product Recurrence Datapath

This block evaluates a two-equation recurrence in dedicated hardware, one input set per clock. Each accepted set (a, b, c, e) adds a and b into a one-sample delay register. It then forms the output from the sum stored by the previous accepted set: that stored sum minus c, times e. The datapath uses exactly one adder, one subtractor, one multiplier and one algorithmic delay register.

The block is meant for a streaming pipeline where the input rate is one set per cycle and an upstream valid flag can leave gaps. A build-time parameter adds a timing register between the subtractor and the multiplier. This breaks the longest combinational path at the cost of one cycle of latency, and the output valid flag tracks that latency exactly. All values are signed two's complement.

Top module: `recur_datapath`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, the delay register captures a+b, truncated to W bits (modulo 2^W).
- R2: The output for an accepted set uses the sum captured by the previous accepted set. The first accepted set after reset uses zero as that previous sum.
- R3: For an accepted set, `y_out` equals the product of two signed values: (previous sum − c) wrapped to W signed bits, and e. The product is given at its full 2W-bit signed width.
- R4: With PIPE=0, `out_valid` and its `y_out` appear one clock after the accepting edge. With PIPE=1 they appear two clocks after it. `out_valid` is high for exactly one cycle per accepted set.
- R5: Sets accepted on consecutive edges each produce a result on consecutive cycles, with no stall.
- R6: An edge with `in_valid` low leaves the delay register unchanged. The next accepted set still uses the sum from the last accepted set.
- R7: While `out_valid` is low, `y_out` holds its previous value.
- R8: A synchronous active-high `rst` clears the delay register, any pipeline state, `y_out` and `out_valid` to zero.
- R9: Extreme operands give exact signed results. For W=8, y_out lies within −16256 to 16384, and (−128)·(−128) gives 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set on a_in..e_in is accepted this cycle |
| a_in | input | W | First addend, signed |
| b_in | input | W | Second addend, signed |
| c_in | input | W | Subtrahend, signed |
| e_in | input | W | Multiplier operand, signed |
| out_valid | output | 1 | y_out carries a new result |
| y_out | output | 2W | Signed product result |

## Verification
If the delay register were wrong, the damage would not show on the output of the set that caused it. It would show on the next accepted set's result, one or two cycles after that set's edge, depending on PIPE. An idle cycle that wrongly advanced the register would therefore surface only at the first result after the gap. A misaligned pipeline stage shows as `out_valid` pulses shifted by a cycle, or as results paired with the wrong e. Both forms are caught on the first affected cycle by comparing each cycle against the reference model, for both values of PIPE.

// File: rtl/recur_datapath.sv
module recur_datapath #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   a_in,
  input  logic signed [W-1:0]   b_in,
  input  logic signed [W-1:0]   c_in,
  input  logic signed [W-1:0]   e_in,
  output logic                  out_valid,
  output logic signed [2*W-1:0] y_out
);
  localparam int PW = 2 * W;

  logic signed [W-1:0]  sum_q;
  logic signed [W-1:0]  sum_now;
  logic signed [W-1:0]  diff;
  logic signed [W-1:0]  mul_a;
  logic signed [W-1:0]  mul_b;
  logic                 mul_v;
  logic signed [PW-1:0] prod;

  assign sum_now = a_in + b_in;
  assign diff    = sum_q - c_in;

  always_ff @(posedge clk) begin
    if (rst)           sum_q <= '0;
    else if (in_valid) sum_q <= sum_now;
  end

  generate
    if (PIPE) begin : g_pipe
      logic signed [W-1:0] diff_q;
      logic signed [W-1:0] e_q;
      logic                v_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          diff_q <= '0;
          e_q    <= '0;
          v_q    <= 1'b0;
        end else begin
          v_q <= in_valid;
          if (in_valid) begin
            diff_q <= diff;
            e_q    <= e_in;
          end
        end
      end
      assign mul_a = diff_q;
      assign mul_b = e_q;
      assign mul_v = v_q;
    end else begin : g_direct
      assign mul_a = diff;
      assign mul_b = e_in;
      assign mul_v = in_valid;
    end
  endgenerate

  assign prod = mul_a * mul_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= mul_v;
      if (mul_v) y_out <= prod;
    end
  end
endmodule

module recur_datapath_chk #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic signed [W-1:0]   e_in,
  input logic                  out_valid,
  input logic signed [2*W-1:0] y_out
);
  localparam int HALF = 2 ** (W - 1);
  localparam int YMAX = HALF * HALF;
  localparam int YMIN = -(HALF * (HALF - 1));

  logic v1, v2, z1, z2, armed;
  logic exp_v, exp_z;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; z1 <= 1'b0; z2 <= 1'b0; armed <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      z1 <= in_valid && (e_in == '0);
      z2 <= z1;
      armed <= 1'b1;
    end
  end

  assign exp_v = PIPE ? v2 : v1;
  assign exp_z = PIPE ? z2 : z1;

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == exp_v));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> $stable(y_out));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (y_out == '0 && !out_valid));

  assert_zero_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid && exp_z) |-> (y_out == '0));

  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> (int'(y_out) <= YMAX && int'(y_out) >= YMIN));
endmodule

bind recur_datapath recur_datapath_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .e_in(e_in),
  .out_valid(out_valid), .y_out(y_out)
);

// File: tb/recur_datapath_bench.sv
module recur_datapath_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] a = '0, b = '0, c = '0, e = '0;
  logic ov0, ov1;
  logic signed [2*W-1:0] y0, y1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R8";

  always #5 clk = ~clk;

  recur_datapath #(.W(W), .PIPE(1'b0)) u_recur_datapath (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .c_in(c), .e_in(e), .out_valid(ov0), .y_out(y0));

  recur_datapath #(.W(W), .PIPE(1'b1)) u_recur_datapath_piped (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .c_in(c), .e_in(e), .out_valid(ov1), .y_out(y1));

  logic signed [W-1:0] dm;
  bit m0v, s1v, m1v;
  int m0o, s1o, m1o;

  always @(posedge clk) begin
    logic signed [W-1:0] df;
    int p;
    if (rst) begin
      dm = '0; m0v = 0; s1v = 0; m1v = 0; m0o = 0; s1o = 0; m1o = 0;
    end else begin
      df = dm - c;
      p  = int'(df) * int'(e);
      m1v = s1v;
      if (s1v) m1o = s1o;
      s1v = in_valid;
      if (in_valid) s1o = p;
      m0v = in_valid;
      if (in_valid) m0o = p;
      if (in_valid) dm = a + b;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("PIPE0 out_valid (R4)", int'(ov0), int'(m0v));
      cmp("PIPE0 y_out", int'(y0), m0o);
      cmp("PIPE1 out_valid (R4)", int'(ov1), int'(m1v));
      cmp("PIPE1 y_out", int'(y1), m1o);
    end
  end

  task automatic drive(input bit v, input int av, input int bv, input int cv, input int ev);
    @(negedge clk); #1;
    in_valid = v; a = W'(av); b = W'(bv); c = W'(cv); e = W'(ev);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    int ext[4] = '{-128, 127, 0, -1};
    tag = "R8 reset state";
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    tag = "R2 first set uses zero";
    drive(1, 10, 20, 3, 7);
    drive(1, 1, 2, 5, -4);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);

    tag = "R1 R3 R5 back-to-back stream";
    for (int i = 0; i < 300; i++)
      drive(1, $urandom, $urandom, $urandom, $urandom);

    tag = "R6 R7 gaps keep sum and hold output";
    for (int i = 0; i < 300; i++)
      drive(($urandom % 2) == 0, $urandom, $urandom, $urandom, $urandom);
    drive(1, 100, 27, 0, 1);
    for (int i = 0; i < 5; i++) drive(0, 55, 66, 77, 88);
    drive(1, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);

    tag = "R9 extreme operands";
    drive(1, -128, 0, 0, 0);
    drive(1, 0, 0, 0, -128);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          drive(1, ext[i], ext[j], ext[k], ext[(i + j + k) % 4]);
    drive(0, 0, 0, 0, 0);

    tag = "R8 mid-stream reset";
    drive(1, 50, 50, 1, 2);
    @(negedge clk); #1 rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk); #1 rst = 1'b0; in_valid = 1'b0;
    tag = "R2 zero after reset";
    drive(1, 9, 9, 4, 3);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R5 act=running exp=finished");
      summary();
    end
  end
endmodule